// File: doc/BRIEF.md
# Interrupt Exception Entry Sequencer

This block performs the hardware part of taking an interrupt. An upstream controller presents a pending request with a priority level and an optional vector number. The core raises a strobe in the first execute cycle of each instruction. When that strobe meets a pending request while the sequencer is idle, the sequencer accepts the request. It captures the current status register, program counter and stack pointer, and in the next cycle publishes a rewritten status register for the core to load.

The vector number comes from one of two places, chosen by a control input sampled at acceptance. One is the number that arrived together with the request. The other is the result of an acknowledge read, which carries the serviced level to the controller and waits for its reply. The sequencer then writes an 8-byte frame to the supervisor stack through a 32-bit write port with a valid/ready handshake. Last, it raises a one-cycle completion pulse together with the handler fetch address and the new stack pointer.

Top module: `exc_entry_seq`

## Requirements
- R1: A request is accepted only on a clock edge where the sequencer is idle and both `sample_i` and `irq_pend_i` are 1. `sr_wr_o` is 1 for exactly the one cycle after that edge. A strobe without a pending request, or any strobe while the sequencer is busy (including the completion cycle), is ignored.
- R2: While `sr_wr_o` is 1, `sr_new_o` equals the captured status register with these changes: bit 13 (supervisor) set, bit 15 (trace) cleared, bit 12 (master) cleared, and bits 10:8 (mask) loaded with the accepted level. All other bits are unchanged.
- R3: If `ack_en_i` was 0 at acceptance, the vector used is `irq_vec_i` as captured at acceptance, and no acknowledge read takes place.
- R4: If `ack_en_i` was 1 at acceptance, `ack_req_o` is 1 from the cycle after acceptance. `ack_lvl_o` carries the accepted level. Both hold until the edge where `ack_valid_i` is 1, and `ack_vec_i` at that edge becomes the vector. `ack_valid_i` has no effect at any other time. The acknowledge read never overlaps a stack write or the completion pulse.
- R5: The frame base is the captured stack pointer with bits 1:0 cleared, minus 8. Every write address is a multiple of 4, and `sp_o` equals the frame base during the completion pulse.
- R6: The first stack write places the captured program counter at frame base + 4.
- R7: The second stack write places the format word at the frame base. The vector occupies bits 25:18, the captured status register occupies bits 15:0, and all other bits are 0.
- R8: While `wr_valid_o` is 1 and `wr_ready_i` is 0, `wr_valid_o`, `wr_addr_o` and `wr_data_o` hold their values into the next cycle. A write completes only at an edge where both are 1.
- R9: `done_o` is 1 for exactly one cycle, the cycle right after the second write is accepted. In that cycle `fetch_addr_o` equals `vtab_base_i` plus four times the vector. The sequencer is idle in the cycle after the pulse.
- R10: While `rst_n` is 0, `sr_wr_o`, `ack_req_o`, `wr_valid_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | First-execute-cycle interrupt sample strobe |
| irq_pend_i | input | 1 | Interrupt request pending |
| irq_lvl_i | input | 3 | Level of the pending request |
| irq_vec_i | input | 8 | Vector supplied with the request |
| ack_en_i | input | 1 | 1: obtain vector by acknowledge read |
| sr_i | input | 16 | Current status register |
| pc_i | input | 32 | Current program counter |
| sp_i | input | 32 | Current supervisor stack pointer |
| vtab_base_i | input | 32 | Vector table base address |
| ack_req_o | output | 1 | Acknowledge read request |
| ack_lvl_o | output | 3 | Level being acknowledged |
| ack_valid_i | input | 1 | Acknowledge reply valid |
| ack_vec_i | input | 8 | Vector returned by acknowledge |
| wr_valid_o | output | 1 | Stack write valid |
| wr_addr_o | output | 32 | Stack write address |
| wr_data_o | output | 32 | Stack write data |
| wr_ready_i | input | 1 | Stack write accepted |
| sr_wr_o | output | 1 | Load strobe for the rewritten status register |
| sr_new_o | output | 16 | Rewritten status register |
| sp_o | output | 32 | New stack pointer (frame base) |
| done_o | output | 1 | Entry complete, handler fetch issued |
| fetch_addr_o | output | 32 | Handler fetch address |

## Verification
Two events can fall in the same cycle: a new sample strobe with a pending request, and an entry already in progress. The entry may be stalled in a write, waiting on the acknowledge, or in its completion cycle. The bench holds the strobe and the pending request high for long stretches and throttles `wr_ready_i` and `ack_valid_i`. A strobe therefore lands in every busy state, including the completion cycle and the idle cycle right after it. A behavioural model in the bench predicts `sr_wr_o` and every other output on each clock. Any accepted strobe while busy, or any strobe missed right after completion, shows up as a mismatch.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int AW          = 32;  // address and data width
  localparam int SRW         = 16;  // status register width
  localparam int LVW         = 3;   // request level width
  localparam int VW          = 8;   // vector number width
  localparam int T_BIT       = 15;  // trace
  localparam int S_BIT       = 13;  // supervisor
  localparam int M_BIT       = 12;  // master
  localparam int MASK_LSB    = 8;   // mask field low bit
  localparam int VEC_LSB     = 18;  // vector field in format word
  localparam int FRAME_BYTES = 8;
  localparam int WORD_BYTES  = 4;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ACK  = 3'd1,
    ST_PC   = 3'd2,
    ST_FMT  = 3'd3,
    ST_DONE = 3'd4
  } seq_state_t;

  function automatic logic [SRW-1:0] entry_sr(input logic [SRW-1:0] sr,
                                               input logic [LVW-1:0] lvl);
    logic [SRW-1:0] r;
    r = sr;
    r[T_BIT] = 1'b0;
    r[S_BIT] = 1'b1;
    r[M_BIT] = 1'b0;
    r[MASK_LSB +: LVW] = lvl;
    return r;
  endfunction

  function automatic logic [AW-1:0] frame_base(input logic [AW-1:0] sp);
    return {sp[AW-1:2], 2'b00} - AW'(FRAME_BYTES);
  endfunction

  function automatic logic [AW-1:0] fmt_word(input logic [VW-1:0] vec,
                                             input logic [SRW-1:0] sr);
    logic [AW-1:0] w;
    w = '0;
    w[VEC_LSB +: VW] = vec;
    w[SRW-1:0] = sr;
    return w;
  endfunction

  function automatic logic [AW-1:0] handler_addr(input logic [AW-1:0] base,
                                                 input logic [VW-1:0] vec);
    return base + (AW'(vec) << 2);
  endfunction
endpackage

// File: rtl/exc_sr_rewrite.sv
module exc_sr_rewrite
  import exc_entry_pkg::*;
(
  input  logic [SRW-1:0] saved_sr_i,
  input  logic [LVW-1:0] lvl_i,
  output logic [SRW-1:0] new_sr_o
);
  always_comb new_sr_o = entry_sr(saved_sr_i, lvl_i);
endmodule

// File: rtl/exc_frame_gen.sv
module exc_frame_gen
  import exc_entry_pkg::*;
(
  input  logic [AW-1:0]  base_i,
  input  logic [AW-1:0]  pc_i,
  input  logic [VW-1:0]  vec_i,
  input  logic [SRW-1:0] saved_sr_i,
  input  logic [AW-1:0]  vtab_base_i,
  input  logic           is_fmt_i,
  output logic [AW-1:0]  wr_addr_o,
  output logic [AW-1:0]  wr_data_o,
  output logic [AW-1:0]  fetch_addr_o
);
  always_comb begin
    if (is_fmt_i) begin
      wr_addr_o = base_i;
      wr_data_o = fmt_word(vec_i, saved_sr_i);
    end else begin
      wr_addr_o = base_i + AW'(WORD_BYTES);
      wr_data_o = pc_i;
    end
    fetch_addr_o = handler_addr(vtab_base_i, vec_i);
  end
endmodule

// File: rtl/exc_entry_ctl.sv
module exc_entry_ctl
  import exc_entry_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sample_i,
  input  logic           pend_i,
  input  logic [LVW-1:0] lvl_i,
  input  logic [VW-1:0]  vec_i,
  input  logic           ack_en_i,
  input  logic [SRW-1:0] sr_i,
  input  logic [AW-1:0]  pc_i,
  input  logic [AW-1:0]  sp_i,
  input  logic           ack_valid_i,
  input  logic [VW-1:0]  ack_vec_i,
  input  logic           wr_ready_i,
  output logic           accept_o,
  output logic           sr_wr_o,
  output logic           ack_req_o,
  output logic           wr_valid_o,
  output logic           wr_fire_o,
  output logic           is_fmt_o,
  output logic           done_o,
  output logic [LVW-1:0] lvl_q_o,
  output logic [VW-1:0]  vec_q_o,
  output logic [SRW-1:0] sr_q_o,
  output logic [AW-1:0]  pc_q_o,
  output logic [AW-1:0]  base_q_o
);
  seq_state_t state;
  logic       sr_wr_q;

  assign accept_o   = (state == ST_IDLE) && sample_i && pend_i;
  assign ack_req_o  = (state == ST_ACK);
  assign wr_valid_o = (state == ST_PC) || (state == ST_FMT);
  assign is_fmt_o   = (state == ST_FMT);
  assign done_o     = (state == ST_DONE);
  assign wr_fire_o  = wr_valid_o && wr_ready_i;
  assign sr_wr_o    = sr_wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sr_wr_q  <= 1'b0;
      lvl_q_o  <= '0;
      vec_q_o  <= '0;
      sr_q_o   <= '0;
      pc_q_o   <= '0;
      base_q_o <= '0;
    end else begin
      sr_wr_q <= accept_o;
      unique case (state)
        ST_IDLE: if (accept_o) begin
          lvl_q_o  <= lvl_i;
          vec_q_o  <= vec_i;
          sr_q_o   <= sr_i;
          pc_q_o   <= pc_i;
          base_q_o <= frame_base(sp_i);
          state    <= ack_en_i ? ST_ACK : ST_PC;
        end
        ST_ACK: if (ack_valid_i) begin
          vec_q_o <= ack_vec_i;
          state   <= ST_PC;
        end
        ST_PC:   if (wr_ready_i) state <= ST_FMT;
        ST_FMT:  if (wr_ready_i) state <= ST_DONE;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1
  sr_wr_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_o |-> $past(sample_i && pend_i));
  // R4
  one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack_req_o, wr_valid_o, done_o}));
  // R8
  write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(is_fmt_o));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !wr_valid_o && !ack_req_o);
  // R9
  done_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(wr_fire_o));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sample_i,
  input  logic           irq_pend_i,
  input  logic [LVW-1:0] irq_lvl_i,
  input  logic [VW-1:0]  irq_vec_i,
  input  logic           ack_en_i,
  input  logic [SRW-1:0] sr_i,
  input  logic [AW-1:0]  pc_i,
  input  logic [AW-1:0]  sp_i,
  input  logic [AW-1:0]  vtab_base_i,
  output logic           ack_req_o,
  output logic [LVW-1:0] ack_lvl_o,
  input  logic           ack_valid_i,
  input  logic [VW-1:0]  ack_vec_i,
  output logic           wr_valid_o,
  output logic [AW-1:0]  wr_addr_o,
  output logic [AW-1:0]  wr_data_o,
  input  logic           wr_ready_i,
  output logic           sr_wr_o,
  output logic [SRW-1:0] sr_new_o,
  output logic [AW-1:0]  sp_o,
  output logic           done_o,
  output logic [AW-1:0]  fetch_addr_o
);
  logic           accept_w;
  logic           wr_fire_w;
  logic           is_fmt_w;
  logic [LVW-1:0] lvl_q;
  logic [VW-1:0]  vec_q;
  logic [SRW-1:0] sr_q;
  logic [AW-1:0]  pc_q;
  logic [AW-1:0]  base_q;

  exc_entry_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_i    (sample_i),
    .pend_i      (irq_pend_i),
    .lvl_i       (irq_lvl_i),
    .vec_i       (irq_vec_i),
    .ack_en_i    (ack_en_i),
    .sr_i        (sr_i),
    .pc_i        (pc_i),
    .sp_i        (sp_i),
    .ack_valid_i (ack_valid_i),
    .ack_vec_i   (ack_vec_i),
    .wr_ready_i  (wr_ready_i),
    .accept_o    (accept_w),
    .sr_wr_o     (sr_wr_o),
    .ack_req_o   (ack_req_o),
    .wr_valid_o  (wr_valid_o),
    .wr_fire_o   (wr_fire_w),
    .is_fmt_o    (is_fmt_w),
    .done_o      (done_o),
    .lvl_q_o     (lvl_q),
    .vec_q_o     (vec_q),
    .sr_q_o      (sr_q),
    .pc_q_o      (pc_q),
    .base_q_o    (base_q)
  );

  exc_sr_rewrite u_sr (
    .saved_sr_i (sr_q),
    .lvl_i      (lvl_q),
    .new_sr_o   (sr_new_o)
  );

  exc_frame_gen u_frame (
    .base_i       (base_q),
    .pc_i         (pc_q),
    .vec_i        (vec_q),
    .saved_sr_i   (sr_q),
    .vtab_base_i  (vtab_base_i),
    .is_fmt_i     (is_fmt_w),
    .wr_addr_o    (wr_addr_o),
    .wr_data_o    (wr_data_o),
    .fetch_addr_o (fetch_addr_o)
  );

  assign ack_lvl_o = lvl_q;
  assign sp_o      = base_q;

  // R2
  sr_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_o |-> sr_new_o[MASK_LSB +: LVW] == $past(irq_lvl_i) && sr_new_o[S_BIT]
                && !sr_new_o[T_BIT] && !sr_new_o[M_BIT]);
  // R5
  wr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> wr_addr_o[1:0] == 2'b00);
  // R8
  wr_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && !wr_ready_i |=> $stable(wr_addr_o) && $stable(wr_data_o));
  // R6
  pc_then_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid_o) |-> wr_addr_o == sp_o + 32'd4);
  // R1
  accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |-> !wr_fire_w && !done_o);
endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_i = 1'b0, irq_pend_i = 1'b0, ack_en_i = 1'b0;
  logic [2:0]  irq_lvl_i = '0;
  logic [7:0]  irq_vec_i = '0, ack_vec_i = '0;
  logic [15:0] sr_i = '0;
  logic [31:0] pc_i = '0, sp_i = '0, vtab_base_i = '0;
  logic        ack_valid_i = 1'b0, wr_ready_i = 1'b0;
  logic        ack_req_o, wr_valid_o, sr_wr_o, done_o;
  logic [2:0]  ack_lvl_o;
  logic [31:0] wr_addr_o, wr_data_o, sp_o, fetch_addr_o;
  logic [15:0] sr_new_o;

  always #2.5 clk = ~clk;  // 200 MHz

  exc_entry_seq u_dut (.*);

  integer compared = 0, mismatched = 0, cycles = 0;
  bit     finished = 0;

  // behavioural model: 0 idle, 1 ack, 2 pc write, 3 format write, 4 done
  integer      m_ph = 0;
  bit          m_srwr = 0;
  logic [15:0] m_sr = '0;
  logic [2:0]  m_lvl = '0;
  logic [7:0]  m_vec = '0;
  logic [31:0] m_pc = '0, m_sp = '0;
  bit          m_acken = 0;

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (!rst_n) begin
      m_ph = 0; m_srwr = 0;
    end else begin
      m_srwr = (m_ph == 0) && sample_i && irq_pend_i;
      case (m_ph)
        0: if (m_srwr) begin
             m_sr = sr_i; m_lvl = irq_lvl_i; m_vec = irq_vec_i;
             m_pc = pc_i; m_sp = sp_i; m_acken = ack_en_i;
             m_ph = ack_en_i ? 1 : 2;
           end
        1: if (ack_valid_i) begin m_vec = ack_vec_i; m_ph = 2; end
        2: if (wr_ready_i) m_ph = 3;
        3: if (wr_ready_i) m_ph = 4;
        default: m_ph = 0;
      endcase
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared = compared + 1;
    if (act !== exp) begin
      mismatched = mismatched + 1;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cycles, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_base(input logic [31:0] sp);
    return (sp - (sp % 4)) - 32'd8;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R10 sr_wr_o", {31'd0, sr_wr_o}, 0);
      chk("R10 ack_req_o", {31'd0, ack_req_o}, 0);
      chk("R10 wr_valid_o", {31'd0, wr_valid_o}, 0);
      chk("R10 done_o", {31'd0, done_o}, 0);
    end else if (!finished) begin
      chk("R1 sr_wr_o", {31'd0, sr_wr_o}, {31'd0, m_srwr});
      if (m_srwr)
        chk("R2 sr_new_o", {16'd0, sr_new_o},
            {16'd0, (m_sr & 16'h68FF) | 16'h2000 | (16'(m_lvl) * 16'd256)});
      chk("R4 ack_req_o", {31'd0, ack_req_o}, (m_ph == 1) ? 1 : 0);
      if (m_ph == 1) chk("R4 ack_lvl_o", {29'd0, ack_lvl_o}, {29'd0, m_lvl});
      chk("R8 wr_valid_o", {31'd0, wr_valid_o}, (m_ph == 2 || m_ph == 3) ? 1 : 0);
      if (m_ph == 2) begin
        chk("R6 wr_addr_o", wr_addr_o, exp_base(m_sp) + 32'd4);
        chk("R6 wr_data_o", wr_data_o, m_pc);
      end
      if (m_ph == 3) begin
        chk("R5 wr_addr_o", wr_addr_o, exp_base(m_sp));
        chk("R7 wr_data_o", wr_data_o, 32'(m_vec) * 32'h40000 + 32'(m_sr));
      end
      chk("R9 done_o", {31'd0, done_o}, (m_ph == 4) ? 1 : 0);
      if (m_ph == 4) begin
        chk(m_acken ? "R9 fetch_addr_o" : "R3 fetch_addr_o",
            fetch_addr_o, vtab_base_i + 32'(m_vec) * 32'd4);
        chk("R5 sp_o", sp_o, exp_base(m_sp));
      end
    end
  end

  task automatic drive(input int rdy_pct, input int smp_pct, input int ack_pct);
    @(negedge clk); #1;
    sample_i    = ($urandom % 100) < smp_pct;
    irq_pend_i  = ($urandom % 100) < 70;
    irq_lvl_i   = 3'($urandom % 7 + 1);
    irq_vec_i   = 8'($urandom);
    ack_en_i    = $urandom % 2;
    sr_i        = 16'($urandom);
    pc_i        = $urandom;
    sp_i        = $urandom;
    vtab_base_i = $urandom;
    ack_valid_i = ($urandom % 100) < ack_pct;
    ack_vec_i   = 8'($urandom);
    wr_ready_i  = ($urandom % 100) < rdy_pct;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    // directed: unaligned stack, top vector, level 7, direct vector (R3, R5)
    sample_i = 1; irq_pend_i = 1; irq_lvl_i = 3'd7; irq_vec_i = 8'hFF;
    ack_en_i = 0; sr_i = 16'hFFFF; pc_i = 32'h1234_5678; sp_i = 32'h0000_1003;
    vtab_base_i = 32'h0000_8000; wr_ready_i = 1;
    @(negedge clk); #1 sample_i = 0;
    repeat (8) @(negedge clk);
    // directed: acknowledge path with vector 0, long ack wait (R4)
    #1 sample_i = 1; irq_lvl_i = 3'd1; ack_en_i = 1; sp_i = 32'h0000_0004;
    sr_i = 16'h0000; ack_valid_i = 0;
    @(negedge clk); #1 sample_i = 0;
    repeat (5) @(negedge clk);
    #1 ack_valid_i = 1; ack_vec_i = 8'h00;
    @(negedge clk); #1 ack_valid_i = 0;
    repeat (8) @(negedge clk);
    // random segments: free-flowing, throttled, heavy stalls, back-to-back strobes
    for (int i = 0; i < 1500; i++) drive(100, 30, 50);
    for (int i = 0; i < 1500; i++) drive(50, 30, 30);
    for (int i = 0; i < 1500; i++) drive(20, 50, 15);
    for (int i = 0; i < 1500; i++) drive(70, 100, 60);
    @(negedge clk); #1 sample_i = 0;
    repeat (4) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    if (!finished) begin
      finished = 1;
      mismatched = mismatched + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule